// File: doc/BRIEF.md
# CSR Access and System Unit

This unit executes system-class instruction words for a scalar integer core. In the same cycle the instruction is presented with its valid strobe, it decodes the word and does one of two things. It either performs an atomic read-modify-write on a control/status register, or it reports an environment-call fault, a breakpoint fault or an illegal encoding. For a CSR access, the value the register held before the instruction appears on the result port in that same cycle, so it can be written to the destination register. The update itself lands on the following clock edge.

The register space holds a parameterised bank of scratch registers at consecutive addresses starting at `SCRATCH_BASE`. It also holds one constant read-only register at `RO_ADDR`. Addresses whose bits 11:10 are both 1 form read-only space. Three operations are supported, each in a register-source form and a 5-bit immediate-source form: write, set bits and clear bits. The set and clear forms perform no write at all when their mask is zero. This allows read-only registers to be read through them.

Top module: `csr_sys_unit`

## Requirements
- R1: While reset is low, and after it is released, every scratch register reads as zero.
- R2: With opcode 0x73, funct3 value 1 writes the register operand, value 2 writes old OR operand, and value 3 writes old AND NOT operand. The CSR address is instruction bits 31:20. The new value is visible from the clock edge that samples valid.
- R3: Funct3 values 5, 6 and 7 perform the same three operations, using instruction bits 19:15 zero-extended as the source.
- R4: While valid is high, `csr_rdata` shows the value the addressed register held before this instruction, including when the previous cycle wrote that same register.
- R5: A set or clear whose source value is zero leaves the register unchanged. A write whose source value is zero stores zero.
- R6: With funct3 0, funct12 0x000 raises `ecall_flt` only and funct12 0x001 raises `ebreak_flt` only. At most one of the three flags is high in any cycle.
- R7: With funct3 0, funct12 0x100 raises `illegal` and neither fault.
- R8: An access to an address that is neither a scratch register nor the read-only register raises `illegal`, returns zero on `csr_rdata` and changes no register.
- R9: A write, or a set or clear with a nonzero source, to an address with bits 11:10 equal to 3 raises `illegal`. A zero-source set or clear to the read-only register is legal and returns `RO_VALUE`.
- R10: Funct3 value 4, any funct3-0 funct12 other than 0x000 or 0x001, and any opcode other than 0x73 raise `illegal`.
- R11: With valid low, all flags and `csr_rdata` are zero and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid | input | 1 | Instruction word is present this cycle |
| instr | input | 32 | Instruction word |
| rs1_val | input | XLEN | Register operand 1 value |
| csr_rdata | output | XLEN | Prior CSR value for the destination register; zero otherwise |
| ecall_flt | output | 1 | Environment-call fault |
| ebreak_flt | output | 1 | Breakpoint fault |
| illegal | output | 1 | Illegal or unimplemented encoding or access |

## Verification
Within one instruction, the combinational read of the old value and the registered write of the new value happen in the same cycle. Across instructions, a write on one edge and the read by the next instruction fall into adjacent cycles. The bench provokes both by issuing back-to-back accesses to the same scratch register with no idle cycle between them. The result port is sampled mid-cycle, before the edge. Each sample is judged against the value the bench's own model gave after the previous instruction, so a bypass or a missing update shows as a mismatch.

// File: rtl/csr_sys_pkg.sv
package csr_sys_pkg;

    localparam logic [6:0]  OPC_SYSTEM = 7'h73;
    localparam logic [11:0] F12_ECALL  = 12'h000;
    localparam logic [11:0] F12_EBREAK = 12'h001;
    localparam logic [11:0] F12_RET    = 12'h100;

    typedef enum logic [1:0] {
        CSR_OP_NONE = 2'd0,
        CSR_OP_RW   = 2'd1,
        CSR_OP_SET  = 2'd2,
        CSR_OP_CLR  = 2'd3
    } csr_op_e;

    typedef struct packed {
        logic        is_csr;
        csr_op_e     op;
        logic        use_imm;
        logic [11:0] addr;
        logic [4:0]  zimm;
        logic        ecall;
        logic        ebreak;
        logic        bad_enc;
    } sys_dec_t;

endpackage

// File: rtl/csr_sys_decode.sv
module csr_sys_decode
    import csr_sys_pkg::*;
(
    input  logic [31:0] instr,
    output sys_dec_t    dec
);
    logic [6:0]  opcode;
    logic [2:0]  funct3;
    logic [11:0] funct12;
    logic        unused_rd_field;

    assign opcode          = instr[6:0];
    assign funct3          = instr[14:12];
    assign funct12         = instr[31:20];
    assign unused_rd_field = ^instr[11:7];

    always_comb begin
        dec         = '0;
        dec.addr    = funct12;
        dec.zimm    = instr[19:15];
        dec.use_imm = funct3[2];
        if (opcode != OPC_SYSTEM) begin
            dec.bad_enc = 1'b1;
        end else begin
            unique case (funct3)
                3'd0: begin
                    if (funct12 == F12_ECALL) begin
                        dec.ecall = 1'b1;
                    end else if (funct12 == F12_EBREAK) begin
                        dec.ebreak = 1'b1;
                    end else if (funct12 == F12_RET) begin
                        // return-type encoding: recognised, not implemented
                        dec.bad_enc = 1'b1;
                    end else begin
                        dec.bad_enc = 1'b1;
                    end
                end
                3'd4: dec.bad_enc = 1'b1;
                default: begin
                    dec.is_csr = 1'b1;
                    unique case (funct3[1:0])
                        2'd1:    dec.op = CSR_OP_RW;
                        2'd2:    dec.op = CSR_OP_SET;
                        default: dec.op = CSR_OP_CLR;
                    endcase
                end
            endcase
        end
    end
endmodule

// File: rtl/csr_sys_alu.sv
module csr_sys_alu
    import csr_sys_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  csr_op_e         op,
    input  logic [XLEN-1:0] old_val,
    input  logic [XLEN-1:0] src_val,
    output logic [XLEN-1:0] new_val,
    output logic            wr_req
);
    logic src_nz;
    assign src_nz = |src_val;

    always_comb begin
        new_val = old_val;
        wr_req  = 1'b0;
        unique case (op)
            CSR_OP_RW: begin
                new_val = src_val;
                wr_req  = 1'b1;
            end
            CSR_OP_SET: begin
                new_val = old_val | src_val;
                wr_req  = src_nz;
            end
            CSR_OP_CLR: begin
                new_val = old_val & ~src_val;
                wr_req  = src_nz;
            end
            default: begin
                new_val = old_val;
                wr_req  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/csr_sys_file.sv
module csr_sys_file #(
    parameter int              XLEN     = 32,
    parameter int              NUM      = 4,
    parameter logic [11:0]     BASE     = 12'h340,
    parameter logic [11:0]     RO_ADDR  = 12'hC80,
    parameter logic [XLEN-1:0] RO_VALUE = XLEN'(32'h1234_5678)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [11:0]          addr,
    input  logic                 wr_en,
    input  logic [XLEN-1:0]      wr_data,
    output logic                 hit,
    output logic [XLEN-1:0]      rd_val,
    output logic [NUM*XLEN-1:0]  flat
);
    typedef struct packed {
        logic [NUM-1:0][XLEN-1:0] regs;
    } file_state_t;

    file_state_t     state_d, state_q;
    logic [NUM-1:0]  sel;
    logic            ro_sel;

    for (genvar i = 0; i < NUM; i++) begin : g_sel
        localparam logic [11:0] ENTRY_ADDR = 12'(BASE + i);
        assign sel[i] = (addr == ENTRY_ADDR);
    end

    assign ro_sel = (addr == RO_ADDR);
    assign hit    = (|sel) | ro_sel;

    always_comb begin
        rd_val = ro_sel ? RO_VALUE : '0;
        for (int i = 0; i < NUM; i++) begin
            if (sel[i]) rd_val = rd_val | state_q.regs[i];
        end
    end

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < NUM; i++) begin
            if (wr_en && sel[i]) state_d.regs[i] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign flat = state_q.regs;
endmodule

// File: rtl/csr_sys_unit.sv
module csr_sys_unit
    import csr_sys_pkg::*;
#(
    parameter int              XLEN         = 32,
    parameter int              NUM_SCRATCH  = 4,
    parameter logic [11:0]     SCRATCH_BASE = 12'h340,
    parameter logic [11:0]     RO_ADDR      = 12'hC80,
    parameter logic [XLEN-1:0] RO_VALUE     = XLEN'(32'h1234_5678)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] rs1_val,
    output logic [XLEN-1:0] csr_rdata,
    output logic            ecall_flt,
    output logic            ebreak_flt,
    output logic            illegal
);
    sys_dec_t                    dec;
    logic                        hit;
    logic [XLEN-1:0]             old_val;
    logic [XLEN-1:0]             src_val;
    logic [XLEN-1:0]             new_val;
    logic                        wr_req;
    logic                        ro_space;
    logic                        access_bad;
    logic                        wr_en;
    logic [NUM_SCRATCH*XLEN-1:0] csr_flat;

    csr_sys_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    assign src_val = dec.use_imm ? {{(XLEN-5){1'b0}}, dec.zimm} : rs1_val;

    csr_sys_alu #(.XLEN(XLEN)) u_alu (
        .op      (dec.op),
        .old_val (old_val),
        .src_val (src_val),
        .new_val (new_val),
        .wr_req  (wr_req)
    );

    assign ro_space   = (dec.addr[11:10] == 2'b11);
    assign access_bad = dec.is_csr & (~hit | (wr_req & ro_space));
    assign wr_en      = valid & dec.is_csr & hit & wr_req & ~ro_space;

    csr_sys_file #(
        .XLEN     (XLEN),
        .NUM      (NUM_SCRATCH),
        .BASE     (SCRATCH_BASE),
        .RO_ADDR  (RO_ADDR),
        .RO_VALUE (RO_VALUE)
    ) u_file (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (dec.addr),
        .wr_en   (wr_en),
        .wr_data (new_val),
        .hit     (hit),
        .rd_val  (old_val),
        .flat    (csr_flat)
    );

    assign illegal    = valid & (dec.bad_enc | access_bad);
    assign ecall_flt  = valid & dec.ecall;
    assign ebreak_flt = valid & dec.ebreak;
    assign csr_rdata  = (valid & dec.is_csr & ~access_bad) ? old_val : '0;
endmodule

// File: rtl/csr_sys_unit_chk.sv
module csr_sys_unit_chk #(
    parameter int XLEN = 32,
    parameter int NUM  = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                valid,
    input logic [31:0]         instr,
    input logic [XLEN-1:0]     rs1_val,
    input logic [XLEN-1:0]     csr_rdata,
    input logic                ecall_flt,
    input logic                ebreak_flt,
    input logic                illegal,
    input logic [NUM*XLEN-1:0] csr_flat
);
    logic [2:0] f3;
    logic       zero_mask_sc;
    logic       unused_instr_bits;

    assign f3 = instr[14:12];
    assign unused_instr_bits = ^{instr[31:20], instr[11:0]};
    assign zero_mask_sc = valid && (f3 != 3'd0) && (f3 != 3'd4) && (f3[1:0] != 2'd1) &&
                          (f3[2] ? (instr[19:15] == 5'd0) : (rs1_val == '0));

    AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ecall_flt, ebreak_flt, illegal}));                        // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (!ecall_flt && !ebreak_flt && !illegal && csr_rdata == '0)); // R11

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> $stable(csr_flat));                                      // R11

    AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && illegal) |=> $stable(csr_flat));                          // R8

    AST_ZERO_MASK_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        zero_mask_sc |=> $stable(csr_flat));                                // R5

    AST_FAULT_ZERO_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
        (ecall_flt || ebreak_flt || illegal) |-> (csr_rdata == '0));        // R8
endmodule

bind csr_sys_unit csr_sys_unit_chk #(.XLEN(XLEN), .NUM(NUM_SCRATCH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid      (valid),
    .instr      (instr),
    .rs1_val    (rs1_val),
    .csr_rdata  (csr_rdata),
    .ecall_flt  (ecall_flt),
    .ebreak_flt (ebreak_flt),
    .illegal    (illegal),
    .csr_flat   (csr_flat)
);

// File: tb/csr_sys_unit_tb_top.sv
module csr_sys_unit_tb_top;
    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            valid = 1'b0;
    logic [31:0]     instr = '0;
    logic [XLEN-1:0] rs1_val = '0;
    logic [XLEN-1:0] csr_rdata;
    logic            ecall_flt, ebreak_flt, illegal;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    csr_sys_unit dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid      (valid),
        .instr      (instr),
        .rs1_val    (rs1_val),
        .csr_rdata  (csr_rdata),
        .ecall_flt  (ecall_flt),
        .ebreak_flt (ebreak_flt),
        .illegal    (illegal)
    );

    function automatic logic [31:0] mk(input logic [11:0] f12, input logic [4:0] r1,
                                       input logic [2:0] f3);
        return {f12, r1, f3, 5'd10, 7'h73};
    endfunction

    typedef struct packed {
        logic [31:0] ins;
        logic [31:0] src;
        logic [31:0] exp_rd;
        logic [2:0]  exp_fl;   // {ecall, ebreak, illegal}
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        '{mk(12'h340, 5'd6, 3'd1), 32'hA5A5_0F0F, 32'h0000_0000, 3'b000, 4'd2},  // R2 rw, R1 reset value
        '{mk(12'h340, 5'd6, 3'd2), 32'h0000_00F0, 32'hA5A5_0F0F, 3'b000, 4'd2},  // R2 set
        '{mk(12'h340, 5'd6, 3'd3), 32'h0000_000F, 32'hA5A5_0FFF, 3'b000, 4'd2},  // R2 clear
        '{mk(12'h340, 5'd5, 3'd2), 32'h0000_0000, 32'hA5A5_0FF0, 3'b000, 4'd5},  // R5 zero set
        '{mk(12'h340, 5'd5, 3'd3), 32'h0000_0000, 32'hA5A5_0FF0, 3'b000, 4'd5},  // R5 zero clear
        '{mk(12'h340, 5'd0, 3'd1), 32'h0000_0000, 32'hA5A5_0FF0, 3'b000, 4'd5},  // R5 rw of zero
        '{mk(12'h341, 5'd31, 3'd5), 32'hFFFF_FFFF, 32'h0000_0000, 3'b000, 4'd3}, // R3 rwi
        '{mk(12'h341, 5'd0, 3'd6), 32'hFFFF_FFFF, 32'h0000_001F, 3'b000, 4'd3},  // R3 zero-imm set
        '{mk(12'h341, 5'd3, 3'd7), 32'hFFFF_FFFF, 32'h0000_001F, 3'b000, 4'd3},  // R3 clri
        '{mk(12'h341, 5'd2, 3'd6), 32'h0000_0000, 32'h0000_001C, 3'b000, 4'd3},  // R3 seti
        '{mk(12'h341, 5'd1, 3'd2), 32'h0000_0000, 32'h0000_001E, 3'b000, 4'd4},  // R4 read
        '{mk(12'h000, 5'd0, 3'd0), 32'h0000_0000, 32'h0000_0000, 3'b100, 4'd6},  // R6 ecall
        '{mk(12'h001, 5'd0, 3'd0), 32'h0000_0000, 32'h0000_0000, 3'b010, 4'd6},  // R6 ebreak
        '{mk(12'h100, 5'd0, 3'd0), 32'h0000_0000, 32'h0000_0000, 3'b001, 4'd7},  // R7 return type
        '{mk(12'h345, 5'd6, 3'd1), 32'h0000_FFFF, 32'h0000_0000, 3'b001, 4'd8},  // R8 unimplemented
        '{mk(12'hC80, 5'd6, 3'd2), 32'h0000_0000, 32'h1234_5678, 3'b000, 4'd9},  // R9 ro read
        '{mk(12'hC80, 5'd6, 3'd1), 32'h0000_0000, 32'h0000_0000, 3'b001, 4'd9},  // R9 ro write
        '{mk(12'hC80, 5'd1, 3'd6), 32'h0000_0000, 32'h0000_0000, 3'b001, 4'd9},  // R9 ro seti
        '{mk(12'h340, 5'd6, 3'd4), 32'h0000_0001, 32'h0000_0000, 3'b001, 4'd10}, // R10 funct3 4
        '{32'h0000_0033,           32'h0000_0001, 32'h0000_0000, 3'b001, 4'd10}, // R10 opcode
        '{mk(12'h002, 5'd0, 3'd0), 32'h0000_0000, 32'h0000_0000, 3'b001, 4'd10}, // R10 funct12
        '{mk(12'h341, 5'd0, 3'd6), 32'h0000_0000, 32'h0000_001E, 3'b000, 4'd8},  // R8 no change
        '{mk(12'h340, 5'd6, 3'd3), 32'h0000_0000, 32'h0000_0000, 3'b000, 4'd8}   // R8 no change
    };

    task automatic check(input string tag, input logic [31:0] exp_rd, input logic [2:0] exp_fl);
        total++;
        if (csr_rdata !== exp_rd || {ecall_flt, ebreak_flt, illegal} !== exp_fl) begin
            bad++;
            $display("FAIL %s: rd=%h flags=%b expected rd=%h flags=%b",
                     tag, csr_rdata, {ecall_flt, ebreak_flt, illegal}, exp_rd, exp_fl);
        end
    endtask

    task automatic drive(input logic v, input logic [31:0] ins, input logic [31:0] src);
        @(negedge clk);
        valid   = v;
        instr   = ins;
        rs1_val = src;
        #1;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state of every scratch register
        for (int i = 0; i < 4; i++) begin
            drive(1'b1, mk(12'(12'h340 + i), 5'd0, 3'd6), '0);
            check($sformatf("R1 reset value of scratch %0d", i), 32'h0, 3'b000);
        end

        // table walk
        for (int k = 0; k < NV; k++) begin
            drive(1'b1, VEC[k].ins, VEC[k].src);
            check($sformatf("R%0d vector %0d", VEC[k].req, k), VEC[k].exp_rd, VEC[k].exp_fl);
        end

        // R4: back-to-back writes and reads on one register
        drive(1'b1, mk(12'h342, 5'd6, 3'd1), 32'hDEAD_BEEF);
        check("R4 b2b first", 32'h0, 3'b000);
        drive(1'b1, mk(12'h342, 5'd6, 3'd3), 32'h0000_00FF);
        check("R4 b2b second", 32'hDEAD_BEEF, 3'b000);
        drive(1'b1, mk(12'h342, 5'd6, 3'd2), 32'h0000_0000);
        check("R4 b2b third", 32'hDEAD_BE00, 3'b000);

        // R11: no effect with valid low
        drive(1'b0, mk(12'h343, 5'd6, 3'd1), 32'h5555_AAAA);
        check("R11 idle outputs", 32'h0, 3'b000);
        drive(1'b0, mk(12'h000, 5'd0, 3'd0), 32'h0);
        check("R11 idle ecall", 32'h0, 3'b000);
        drive(1'b1, mk(12'h343, 5'd0, 3'd6), 32'h0);
        check("R11 idle left register", 32'h0, 3'b000);

        // R1: reset in mid-run clears written registers
        @(negedge clk);
        valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b1, mk(12'h342, 5'd0, 3'd6), 32'h0);
        check("R1 cleared by reset", 32'h0, 3'b000);
        drive(1'b1, mk(12'h341, 5'd0, 3'd6), 32'h0);
        check("R1 cleared by reset s1", 32'h0, 3'b000);

        @(negedge clk);
        valid = 1'b0;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule